// File: doc/BRIEF.md
# Hilbert Upper-Sideband Demodulator with DAC Clamp

This block turns a decimated complex baseband stream into an audio level for a pulse-width DAC. In-phase and quadrature samples arrive as 16-bit signed words that share one valid strobe. Each valid sample moves both channels' histories along by one place. The quadrature history feeds a 15-tap antisymmetric Hilbert filter. That filter is built only from its even-offset pairs: four integer coefficients (315, 440, 734, 2202), each multiplying the difference of a mirrored pair of samples, with the sum divided by 4096. The Hilbert output is subtracted from the in-phase sample that sits at the centre of the history, seven samples behind the newest one. This lines the two paths up in time and selects the upper sideband.

The difference is halved and a bias is added so the signal sits in the middle of the DAC range. The result is then limited to the legal code range and given out as an unsigned level with a one-cycle valid pulse. The level holds its value between updates, so it can drive a PWM compare register directly.

Top module: `ssb_hilbert_demod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `level` equals DAC_BIAS (default 2048) and `outValid` is 0. Reset also clears both sample histories to zero.
- R2: Every cycle with `inValid` high produces exactly one `outValid` pulse, two clock edges later. `outValid` is never high otherwise.
- R3: The histories shift only on `inValid`. Position 0 holds the oldest quadrature sample and position 14 the newest. The in-phase term used is the sample taken seven valid samples before the newest one (the centre, position 7).
- R4: The Hilbert value is hq = ((q0-q14)*315 + (q2-q12)*440 + (q4-q10)*734 + (q6-q8)*2202) / 4096, summed with at least 32-bit signed precision. Quadrature samples at odd positions have no effect.
- R5: The division by 4096 and the halving of (i7 - hq) both truncate toward zero. For example, -3 halves to -1, and -4095/4096 gives 0.
- R6: The unclamped code is trunc((i7 - hq)/2) + DAC_BIAS.
- R7: An unclamped code below 0 gives a level of 0.
- R8: An unclamped code above DAC_RANGE (default 4095) gives a level of DAC_RANGE. `level` never exceeds DAC_RANGE.
- R9: `level` changes only in the cycle where `outValid` is high.
- R10: Sample values presented while `inValid` is low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample pair valid strobe |
| iSample | input | 16 | In-phase sample, signed |
| qSample | input | 16 | Quadrature sample, signed |
| outValid | output | 1 | One-cycle pulse marking a new level |
| level | output | 12 | Unsigned DAC level, 0 to DAC_RANGE |

## Verification
The checker watches the timing side of the block on every cycle. It checks the reset value, that each input strobe is answered by one output pulse two edges later, that the level stays inside the DAC range, and that the level holds still between pulses.

The arithmetic can only be shown by the bench's scenarios. Each scenario places a single non-zero quadrature sample at a chosen history position, and the checks cover:
- each coefficient's weight and sign;
- the zero odd taps;
- the centre alignment of the in-phase sample;
- truncation toward zero rather than flooring;
- clamping at both ends;
- invalid-cycle data being ignored;
- reset clearing the histories.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  // Length of the quadrature history and its centre position
  localparam int HIST_LEN = 15;
  localparam int CENTRE   = (HIST_LEN - 1) / 2;
  // Number of non-zero mirrored pairs (even offsets only)
  localparam int NPAIRS   = (HIST_LEN + 1) / 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // move histories along and take the new pair
    logic loadOut;   // capture the clamped level
  } hsdStrobe_t;

  // Hilbert weight for pair p, pairing position 2p with HIST_LEN-1-2p
  function automatic int hilbCoef(input int p);
    case (p)
      0:       return 315;
      1:       return 440;
      2:       return 734;
      default: return 2202;
    endcase
  endfunction

endpackage

// File: rtl/hsd_ctrl.sv
module hsd_ctrl
  import hsd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output hsdStrobe_t strobe,
  output logic       outValid
);

  logic loadPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPending <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      loadPending <= inValid;
      outValid    <= loadPending;
    end
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.loadOut = loadPending;
  end

endmodule

// File: rtl/hsd_clamp.sv
module hsd_clamp #(
  parameter int ACC_W     = 32,
  parameter int LEVEL_W   = 12,
  parameter int DAC_RANGE = 4095
) (
  input  logic signed [ACC_W-1:0] value,
  output logic        [LEVEL_W-1:0] code
);

  localparam logic signed [ACC_W-1:0] RANGE_S = ACC_W'(DAC_RANGE);
  localparam logic signed [ACC_W-1:0] ZERO_S  = '0;

  always_comb begin
    if (value < ZERO_S)
      code = '0;
    else if (value > RANGE_S)
      code = LEVEL_W'(DAC_RANGE);
    else
      code = value[LEVEL_W-1:0];
  end

endmodule

// File: rtl/hsd_datapath.sv
module hsd_datapath
  import hsd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LEVEL_W   = 12,
  parameter int ACC_W     = 32,
  parameter int HILB_DIV  = 4096,
  parameter int DAC_BIAS  = 2048,
  parameter int DAC_RANGE = 4095
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  hsdStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] iIn,
  input  logic signed [SAMPLE_W-1:0] qIn,
  output logic        [LEVEL_W-1:0]  level
);

  // In-phase needs only enough depth to reach the centre
  localparam int ILEN = CENTRE + 1;
  localparam logic signed [ACC_W-1:0] DIV_S  = ACC_W'(HILB_DIV);
  localparam logic signed [ACC_W-1:0] TWO_S  = ACC_W'(2);
  localparam logic signed [ACC_W-1:0] BIAS_S = ACC_W'(DAC_BIAS);

  logic signed [SAMPLE_W-1:0] qHist [HIST_LEN];
  logic signed [SAMPLE_W-1:0] iHist [ILEN];

  // Quadrature history: newest at HIST_LEN-1, oldest at 0
  for (genvar k = 0; k < HIST_LEN; k++) begin : g_qHist
    if (k == HIST_LEN - 1) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               qHist[k] <= '0;
        else if (strobe.shiftEn) qHist[k] <= qIn;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               qHist[k] <= '0;
        else if (strobe.shiftEn) qHist[k] <= qHist[k+1];
      end
    end
  end

  // In-phase delay line: newest at ILEN-1, centre sample at 0
  for (genvar k = 0; k < ILEN; k++) begin : g_iHist
    if (k == ILEN - 1) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               iHist[k] <= '0;
        else if (strobe.shiftEn) iHist[k] <= iIn;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               iHist[k] <= '0;
        else if (strobe.shiftEn) iHist[k] <= iHist[k+1];
      end
    end
  end

  // Pair-difference terms, even offsets only
  logic signed [ACC_W-1:0] pairTerm [NPAIRS];
  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = HIST_LEN - 1 - 2 * p;
    localparam logic signed [ACC_W-1:0] COEF = ACC_W'(hilbCoef(p));
    logic signed [ACC_W-1:0] pairDiff;
    assign pairDiff    = ACC_W'(qHist[LO]) - ACC_W'(qHist[HI]);
    assign pairTerm[p] = pairDiff * COEF;
  end

  logic signed [ACC_W-1:0] hilbSum;
  logic signed [ACC_W-1:0] hilbOut;
  logic signed [ACC_W-1:0] sideDiff;
  logic signed [ACC_W-1:0] halved;
  logic signed [ACC_W-1:0] biased;
  logic        [LEVEL_W-1:0] clamped;

  always_comb begin
    hilbSum = '0;
    for (int p = 0; p < NPAIRS; p++) hilbSum = hilbSum + pairTerm[p];
  end

  // Signed division truncates toward zero
  assign hilbOut  = hilbSum / DIV_S;
  assign sideDiff = ACC_W'(iHist[0]) - hilbOut;
  assign halved   = sideDiff / TWO_S;
  assign biased   = halved + BIAS_S;

  hsd_clamp #(
    .ACC_W     (ACC_W),
    .LEVEL_W   (LEVEL_W),
    .DAC_RANGE (DAC_RANGE)
  ) i_clamp (
    .value (biased),
    .code  (clamped)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               level <= LEVEL_W'(DAC_BIAS);
    else if (strobe.loadOut) level <= clamped;
  end

endmodule

// File: rtl/ssb_hilbert_demod.sv
module ssb_hilbert_demod
  import hsd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LEVEL_W   = 12,
  parameter int ACC_W     = 32,
  parameter int HILB_DIV  = 4096,
  parameter int DAC_BIAS  = 2048,
  parameter int DAC_RANGE = 4095
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] iSample,
  input  logic [SAMPLE_W-1:0] qSample,
  output logic                outValid,
  output logic [LEVEL_W-1:0]  level
);

  hsdStrobe_t strobe;

  hsd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hsd_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .LEVEL_W   (LEVEL_W),
    .ACC_W     (ACC_W),
    .HILB_DIV  (HILB_DIV),
    .DAC_BIAS  (DAC_BIAS),
    .DAC_RANGE (DAC_RANGE)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .iIn    ($signed(iSample)),
    .qIn    ($signed(qSample)),
    .level  (level)
  );

endmodule

// File: rtl/ssb_hilbert_demod_chk.sv
module ssb_hilbert_demod_chk #(
  parameter int LEVEL_W   = 12,
  parameter int DAC_BIAS  = 2048,
  parameter int DAC_RANGE = 4095
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               outValid,
  input logic [LEVEL_W-1:0] level
);

  // Edges seen since reset release, saturating
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (level == LEVEL_W'(DAC_BIAS) && !outValid));

  p_pulse_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  p_pulse_has_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sinceRst >= 2'd2) |-> $past(inValid, 2));

  p_no_early_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 2'd2) |-> !outValid);

  p_level_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    level <= LEVEL_W'(DAC_RANGE));

  p_level_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(level));

endmodule

bind ssb_hilbert_demod ssb_hilbert_demod_chk #(
  .LEVEL_W   (LEVEL_W),
  .DAC_BIAS  (DAC_BIAS),
  .DAC_RANGE (DAC_RANGE)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .level    (level)
);

// File: tb/test_ssb_hilbert_demod.sv
module test_ssb_hilbert_demod;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] iSample = '0;
  logic [15:0] qSample = '0;
  logic        outValid;
  logic [11:0] level;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ssb_hilbert_demod i_ssb_hilbert_demod (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .iSample  (iSample),
    .qSample  (qSample),
    .outValid (outValid),
    .level    (level)
  );

  // Columns: centre in-phase value, position of the single quadrature
  // sample (15 = none), its value, expected level. Tag noted per row.
  localparam int NVEC = 19;
  localparam int VEC [NVEC][4] = '{
    '{     0, 15,     0, 2048},  // R6 zero input sits at bias
    '{  1000, 15,     0, 2548},  // R3 R6 centre in-phase, positive
    '{ -1000, 15,     0, 1548},  // R3 R6 centre in-phase, negative
    '{     3, 15,     0, 2049},  // R5 halving truncates
    '{    -3, 15,     0, 2047},  // R5 halving toward zero
    '{     0,  6,  4096,  947},  // R4 weight 2202, lower side
    '{     0,  6, -4096, 3149},  // R4 negative sample
    '{     1,  0,   -13, 2048},  // R5 -4095/4096 gives 0
    '{     0,  0,  4096, 1891},  // R4 R5 weight 315
    '{     0, 14,  4096, 2205},  // R4 weight 315, upper side
    '{     0,  2,  4096, 1828},  // R4 weight 440
    '{     0,  4,  4096, 1681},  // R4 weight 734
    '{     0,  8,  4096, 3149},  // R4 weight 2202, upper side
    '{     0, 10,  4096, 2415},  // R4 weight 734, upper side
    '{     0, 12,  4096, 2268},  // R4 weight 440, upper side
    '{ 20000, 15,     0, 4095},  // R8 clamp high
    '{-20000, 15,     0,    0},  // R7 clamp low
    '{     0,  7, 30000, 2048},  // R4 odd (centre) tap is zero
    '{     0,  1, 30000, 2048}   // R4 odd tap is zero
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic pushSample(input int iv, input int qv);
    @(negedge clk);
    inValid = 1'b1;
    iSample = 16'(iv);
    qSample = 16'(qv);
  endtask

  task automatic idle(input int iv, input int qv);
    @(negedge clk);
    inValid = 1'b0;
    iSample = 16'(iv);
    qSample = 16'(qv);
  endtask

  // Fill all 15 history slots: in-phase only at slot 7, one quadrature
  // value at slot qPos. Optional junk-filled gaps between pushes.
  task automatic loadVector(input int iC, input int qPos, input int qv, input int gap);
    for (int k = 0; k < 15; k++) begin
      pushSample((k == 7) ? iC : 0, (k == qPos) ? qv : 0);
      for (int g = 0; g < gap; g++) idle(12345 + g, -23456 + k);
    end
    idle(0, 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int held;
    repeat (3) @(negedge clk);
    check("R1 level in reset", int'(level), 2048);
    check("R1 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 level after release", int'(level), 2048);
    check("R2 no pulse without input", int'(outValid), 0);

    for (int v = 0; v < NVEC; v++) begin
      loadVector(VEC[v][0], VEC[v][1], VEC[v][2], 0);
      @(negedge clk);
      check($sformatf("R2 pulse vec%0d", v), int'(outValid), 1);
      check($sformatf("R3 R4 R5 R6 R7 R8 level vec%0d", v), int'(level), VEC[v][3]);
      held = int'(level);
      idle(777, -777);
      check($sformatf("R2 single pulse vec%0d", v), int'(outValid), 0);
      check($sformatf("R9 level held vec%0d", v), int'(level), held);
    end

    // R10: junk on the sample inputs between strobes changes nothing
    loadVector(0, 6, 4096, 3);
    @(negedge clk);
    check("R10 gaps ignored", int'(level), 947);
    loadVector(-1000, 15, 0, 2);
    @(negedge clk);
    check("R10 gaps ignored centre", int'(level), 1548);

    // R1: reset clears history. Fill quadrature with 4096 everywhere.
    for (int k = 0; k < 15; k++) pushSample(0, 4096);
    idle(0, 0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 level on mid-run reset", int'(level), 2048);
    check("R1 outValid on mid-run reset", int'(outValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    pushSample(1000, 0);
    for (int k = 0; k < 7; k++) pushSample(0, 0);
    idle(0, 0);
    @(negedge clk);
    check("R1 history cleared by reset", int'(level), 2548);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule